// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This block takes one 32-bit single-register load/store instruction word, together with the base and index register values already read from the register file, and works out the memory request for it. The outputs are the effective address, the direction, the access size and an unprivileged-access flag. It also works out whether the base register is updated, which register that is, and the value written into it. The offset is one of three kinds: a 12-bit unsigned immediate, an index register used as it is, or an index register passed through a barrel shifter. The offset is added to or subtracted from the base.

The block supports three indexing modes. In offset mode the address is base±offset and the base is left alone. In pre-indexed mode the same address is also written back to the base. In post-indexed mode the access uses the raw base, and base±offset is written back afterwards. A post-indexed encoding with the writeback bit set is not a writeback variant: it marks the access as unprivileged. An external evaluator supplies the condition result. If the condition fails, or the word is not of this class, the result strobe still appears, but the request and writeback enables stay low. All results are registered, and each one appears one clock after its input strobe.

Top module: `lsagu_top`

## Requirements
- R1: `valid_o` equals `valid_i` delayed by exactly one clock. While reset is asserted, `valid_o`, `req_o`, `wb_en_o` and `unpriv_o` are low. In a cycle where `valid_o` is low, `req_o` and `wb_en_o` are low.
- R2: `req_o`, `wb_en_o` and `unpriv_o` are forced low when any of the following holds: `cond_pass_i` is low, instruction bits 27:26 are not `01`, or bit 25 is 1 while bit 4 is 1. `valid_o` still rises in these cases.
- R3: When bit 25 is 0, the offset is bits 11:0 zero-extended.
- R4: When bit 23 is 1, the computed value is base+offset. When bit 23 is 0, it is base−offset, modulo 2^32.
- R5: When bit 24 is 1 and bit 21 is 0, `addr_o` is the computed value and `wb_en_o` is low.
- R6: When bit 24 is 1 and bit 21 is 1, `addr_o` is the computed value and `wb_en_o` is high. `wb_data_o` equals `addr_o`, and `wb_reg_o` is bits 19:16.
- R7: When bit 24 is 0, `addr_o` is `base_i` and `wb_en_o` is high. `wb_data_o` is the computed value.
- R8: `unpriv_o` is high exactly when the request is enabled, bit 24 is 0 and bit 21 is 1.
- R9: `load_o` is bit 20 (1 = load) and `byte_o` is bit 22 (1 = unsigned byte).
- R10: When bit 25 is 1, the index register (bits 3:0 select it) is shifted by bits 11:7 with the type in bits 6:5. For type `00`, the shift is a logical left shift. For type `01`, it is a logical right shift, and an amount of 0 means 32, which gives zero.
- R11: Shift type `10` is an arithmetic right shift. An amount of 0 means 32, so every bit becomes a copy of the sign bit.
- R12: Shift type `11` is a rotate right. An amount of 0 rotates right by one through `carry_i`, which enters at bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input strobe |
| instr_i | input | 32 | Instruction word |
| base_i | input | 32 | Base register value |
| index_i | input | 32 | Index register value |
| cond_pass_i | input | 1 | Condition passed |
| carry_i | input | 1 | Carry flag for rotate-through-carry |
| valid_o | output | 1 | Result strobe |
| req_o | output | 1 | Memory request enable |
| addr_o | output | 32 | Effective address |
| load_o | output | 1 | 1 = load, 0 = store |
| byte_o | output | 1 | 1 = byte, 0 = word |
| unpriv_o | output | 1 | Unprivileged access |
| wb_en_o | output | 1 | Base writeback enable |
| wb_reg_o | output | 4 | Base register number |
| wb_data_o | output | 32 | Base writeback value |

## Verification
The assertions assume that `valid_i` is low while reset is held. They also assume that every input is at a known level at each clock edge where `valid_i` is high. Nothing is assumed about the index register value, the shift field, or the relation between the base and the offset. The bench changes inputs only on the falling edge. It holds `valid_i` low through reset and drives every input to a defined value before raising the strobe. Suppressed cases, such as a wrong class, a failed condition or a bad register-form bit 4, are sent with real data on every other input. This lets the address path be compared even when the enables are gated.

// File: rtl/lsagu_pkg.sv
package lsagu_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shift_e;

  typedef struct packed {
    logic        is_class;
    logic        reg_off;
    logic        bad_enc;
    logic        pre;
    logic        up;
    logic        byte_sz;
    logic        wbit;
    logic        load;
    logic [3:0]  base_reg;
    logic [11:0] imm;
    shift_e      sh_type;
    logic [4:0]  sh_amt;
  } lsagu_dec_t;
endpackage

// File: rtl/lsagu_decode.sv
module lsagu_decode
  import lsagu_pkg::*;
(
  input  logic [31:0] instr_i,
  output lsagu_dec_t  dec_o
);
  // condition and destination fields are handled outside this block
  logic unused_bits;
  assign unused_bits = ^{instr_i[31:28], instr_i[15:12]};

  always_comb begin
    dec_o          = '0;
    dec_o.is_class = (instr_i[27:26] == 2'b01);
    dec_o.reg_off  = instr_i[25];
    dec_o.bad_enc  = instr_i[25] & instr_i[4];
    dec_o.pre      = instr_i[24];
    dec_o.up       = instr_i[23];
    dec_o.byte_sz  = instr_i[22];
    dec_o.wbit     = instr_i[21];
    dec_o.load     = instr_i[20];
    dec_o.base_reg = instr_i[19:16];
    dec_o.imm      = instr_i[11:0];
    dec_o.sh_type  = shift_e'(instr_i[6:5]);
    dec_o.sh_amt   = instr_i[11:7];
  end
endmodule

// File: rtl/lsagu_shifter.sv
module lsagu_shifter
  import lsagu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] val_i,
  input  shift_e            type_i,
  input  logic [4:0]        amt_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] res_o
);
  logic              amt_zero;
  logic [2*DATA_W-1:0] rot_wide;

  assign amt_zero = (amt_i == 5'd0);
  assign rot_wide = {val_i, val_i} >> amt_i;

  always_comb begin
    unique case (type_i)
      SH_LSL: res_o = val_i << amt_i;
      SH_LSR: res_o = amt_zero ? '0 : (val_i >> amt_i);
      SH_ASR: res_o = amt_zero ? {DATA_W{val_i[DATA_W-1]}}
                               : DATA_W'($signed(val_i) >>> amt_i);
      SH_ROR: res_o = amt_zero ? {carry_i, val_i[DATA_W-1:1]}
                               : rot_wide[DATA_W-1:0];
      default: res_o = val_i;
    endcase
  end
endmodule

// File: rtl/lsagu_addsub.sv
module lsagu_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              up_i,
  output logic [DATA_W-1:0] sum_o
);
  assign sum_o = up_i ? (a_i + b_i) : (a_i - b_i);
endmodule

// File: rtl/lsagu_top.sv
module lsagu_top
  import lsagu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [31:0]       instr_i,
  input  logic [DATA_W-1:0] base_i,
  input  logic [DATA_W-1:0] index_i,
  input  logic              cond_pass_i,
  input  logic              carry_i,
  output logic              valid_o,
  output logic              req_o,
  output logic [DATA_W-1:0] addr_o,
  output logic              load_o,
  output logic              byte_o,
  output logic              unpriv_o,
  output logic              wb_en_o,
  output logic [3:0]        wb_reg_o,
  output logic [DATA_W-1:0] wb_data_o
);
  localparam int IMM_W = 12;

  lsagu_dec_t        dec;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] offset;
  logic [DATA_W-1:0] calc;
  logic              go;
  logic              wb_go;
  logic              unpriv_go;

  lsagu_decode u_decode (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  lsagu_shifter #(.DATA_W(DATA_W)) u_shifter (
    .val_i   (index_i),
    .type_i  (dec.sh_type),
    .amt_i   (dec.sh_amt),
    .carry_i (carry_i),
    .res_o   (shifted)
  );

  assign offset = dec.reg_off ? shifted
                              : {{(DATA_W-IMM_W){1'b0}}, dec.imm};

  lsagu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a_i   (base_i),
    .b_i   (offset),
    .up_i  (dec.up),
    .sum_o (calc)
  );

  assign go        = valid_i & cond_pass_i & dec.is_class & ~dec.bad_enc;
  // post-indexed always writes back; W only matters when pre-indexed
  assign wb_go     = go & (~dec.pre | dec.wbit);
  // W on a post-indexed form means translation, not writeback
  assign unpriv_go = go & ~dec.pre & dec.wbit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      req_o    <= 1'b0;
      wb_en_o  <= 1'b0;
      unpriv_o <= 1'b0;
    end else begin
      valid_o  <= valid_i;
      req_o    <= go;
      wb_en_o  <= wb_go;
      unpriv_o <= unpriv_go;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o    <= '0;
      load_o    <= 1'b0;
      byte_o    <= 1'b0;
      wb_reg_o  <= '0;
      wb_data_o <= '0;
    end else if (valid_i) begin
      addr_o    <= dec.pre ? calc : base_i;
      load_o    <= dec.load;
      byte_o    <= dec.byte_sz;
      wb_reg_o  <= dec.base_reg;
      wb_data_o <= calc;
    end
  end
endmodule

// File: rtl/lsagu_checker.sv
module lsagu_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [31:0] instr_i,
  input logic [31:0] base_i,
  input logic [31:0] index_i,
  input logic        cond_pass_i,
  input logic        carry_i,
  input logic        valid_o,
  input logic        req_o,
  input logic [31:0] addr_o,
  input logic        load_o,
  input logic        byte_o,
  input logic        unpriv_o,
  input logic        wb_en_o,
  input logic [3:0]  wb_reg_o,
  input logic [31:0] wb_data_o
);
  logic acc_ok;
  assign acc_ok = valid_i & cond_pass_i & (instr_i[27:26] == 2'b01)
                & ~(instr_i[25] & instr_i[4]);

  a_r1_valid_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!req_o && !wb_en_o));

  a_r2_cond_fail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !cond_pass_i) |=> (valid_o && !req_o && !wb_en_o && !unpriv_o));

  a_r2_wrong_class: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && instr_i[27:26] != 2'b01) |=> (!req_o && !wb_en_o));

  a_r5_no_writeback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && instr_i[24] && !instr_i[21]) |=> !wb_en_o);

  a_r6_pre_wb_equals_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && instr_i[24] && instr_i[21]) |=> (wb_data_o == addr_o));

  a_r7_post_uses_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !instr_i[24]) |=> (addr_o == $past(base_i)));

  a_r8_unpriv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (unpriv_o == $past(acc_ok && !instr_i[24] && instr_i[21])));

  a_r8_unpriv_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unpriv_o |-> (req_o && wb_en_o));

  a_r9_attrs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (load_o == $past(instr_i[20]) && byte_o == $past(instr_i[22])));
endmodule

bind lsagu_top lsagu_checker u_chk (.*);

// File: tb/lsagu_top_bench.sv
module lsagu_top_bench;
  typedef struct {
    string       tag;
    logic        req;
    logic [31:0] addr;
    logic        load;
    logic        byte_sz;
    logic        unpriv;
    logic        wb_en;
    logic [3:0]  wb_reg;
    logic [31:0] wb_data;
  } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [31:0] base_i = '0;
  logic [31:0] index_i = '0;
  logic        cond_pass_i = 1'b0;
  logic        carry_i = 1'b0;
  logic        valid_o, req_o, load_o, byte_o, unpriv_o, wb_en_o;
  logic [31:0] addr_o, wb_data_o;
  logic [3:0]  wb_reg_o;

  int   n_chk = 0;
  int   n_fail = 0;
  exp_t sb[$];

  always #5 clk_i = ~clk_i;

  lsagu_top u_lsagu_top (.*);

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t model(input string tag, input logic [31:0] ins,
                                 input logic [31:0] b, input logic [31:0] x,
                                 input logic cp, input logic cin);
    exp_t        e;
    logic [31:0] off, sum;
    int          n;
    n = int'(ins[11:7]);
    if (!ins[25]) off = {20'h0, ins[11:0]};
    else begin
      case (ins[6:5])
        2'b00: off = x << n;
        2'b01: off = (n == 0) ? 32'h0 : x >> n;
        2'b10: off = (n == 0) ? {32{x[31]}} : 32'(signed'(x) >>> n);
        default: off = (n == 0) ? {cin, x[31:1]} : ((x >> n) | (x << (32 - n)));
      endcase
    end
    sum       = ins[23] ? b + off : b - off;
    e.tag     = tag;
    e.req     = cp && ins[27:26] == 2'b01 && !(ins[25] && ins[4]);
    e.addr    = ins[24] ? sum : b;
    e.load    = ins[20];
    e.byte_sz = ins[22];
    e.unpriv  = e.req && !ins[24] && ins[21];
    e.wb_en   = e.req && (!ins[24] || ins[21]);
    e.wb_reg  = ins[19:16];
    e.wb_data = sum;
    return e;
  endfunction

  function automatic logic [31:0] enc(input logic i, p, u, bs, w, l,
                                      input logic [3:0] rn, input logic [11:0] low);
    return {4'hE, 2'b01, i, p, u, bs, w, l, rn, 4'h1, low};
  endfunction

  function automatic logic [11:0] rform(input logic [4:0] amt,
                                        input logic [1:0] ty, input logic [3:0] rm);
    return {amt, ty, 1'b0, rm};
  endfunction

  task automatic send(input string tag, input logic [31:0] ins, input logic [31:0] b,
                      input logic [31:0] x, input logic cp, input logic cin);
    @(negedge clk_i);
    instr_i = ins; base_i = b; index_i = x; cond_pass_i = cp; carry_i = cin;
    valid_i = 1'b1;
    sb.push_back(model(tag, ins, b, x, cp, cin));
  endtask

  task automatic idle();
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && valid_o) begin
      if (sb.size() == 0) check("R1", "unexpected valid_o", 32'd1, 32'd0);
      else begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, "req",     {31'h0, req_o},    {31'h0, e.req});
        check(e.tag, "addr",    addr_o,            e.addr);
        check(e.tag, "load",    {31'h0, load_o},   {31'h0, e.load});
        check(e.tag, "byte",    {31'h0, byte_o},   {31'h0, e.byte_sz});
        check(e.tag, "unpriv",  {31'h0, unpriv_o}, {31'h0, e.unpriv});
        check(e.tag, "wb_en",   {31'h0, wb_en_o},  {31'h0, e.wb_en});
        check(e.tag, "wb_reg",  {28'h0, wb_reg_o}, {28'h0, e.wb_reg});
        check(e.tag, "wb_data", wb_data_o,         e.wb_data);
      end
    end
  end

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #200000;
    check("WDOG", "watchdog expired", 32'd1, 32'd0);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state
    check("R1", "valid_o in reset", {31'h0, valid_o}, 32'h0);
    check("R1", "req_o in reset",   {31'h0, req_o},   32'h0);
    check("R1", "wb_en_o in reset", {31'h0, wb_en_o}, 32'h0);
    rst_ni = 1'b1;

    // R3 R4 R7: immediate post-indexed add
    send("R7", enc(0, 0, 1, 0, 0, 1, 4'h2, 12'hFFF), 32'h0000_1000, 32'h0, 1, 0);
    // R4 R5: immediate offset subtract, no writeback, byte store
    send("R5", enc(0, 1, 0, 1, 0, 0, 4'h3, 12'h010), 32'h0000_0008, 32'h0, 1, 0);
    // R6 R10: pre-indexed LSL 3
    send("R6", enc(1, 1, 1, 0, 1, 1, 4'hD, rform(5'd3, 2'b00, 4'h5)), 32'h2000_0000, 32'h0000_0011, 1, 0);
    // R10: plain register (all shift bits zero)
    send("R10", enc(1, 1, 1, 0, 0, 1, 4'h4, rform(5'd0, 2'b00, 4'h6)), 32'h100, 32'hABCD_0000, 1, 0);
    // R10: LSR by 0 means 32
    send("R10", enc(1, 1, 1, 0, 0, 1, 4'h4, rform(5'd0, 2'b01, 4'h6)), 32'h100, 32'hFFFF_FFFF, 1, 0);
    send("R10", enc(1, 1, 1, 0, 0, 1, 4'h4, rform(5'd4, 2'b01, 4'h6)), 32'h100, 32'h8000_00F0, 1, 0);
    idle();
    // R1: gap cycle shows nothing
    @(negedge clk_i);
    check("R1", "valid_o after gap", {31'h0, valid_o}, 32'h0);
    check("R1", "req_o after gap",   {31'h0, req_o},   32'h0);
    // R11: ASR
    send("R11", enc(1, 1, 0, 0, 0, 1, 4'h7, rform(5'd0, 2'b10, 4'h1)), 32'h50, 32'h8000_0000, 1, 0);
    send("R11", enc(1, 1, 1, 0, 0, 1, 4'h7, rform(5'd5, 2'b10, 4'h1)), 32'h50, 32'hF000_0000, 1, 0);
    // R12: ROR and rotate-through-carry
    send("R12", enc(1, 1, 1, 0, 0, 1, 4'h8, rform(5'd0, 2'b11, 4'h2)), 32'h0, 32'h0000_0003, 1, 1);
    send("R12", enc(1, 1, 1, 0, 0, 1, 4'h8, rform(5'd0, 2'b11, 4'h2)), 32'h0, 32'h0000_0003, 1, 0);
    send("R12", enc(1, 1, 1, 0, 0, 1, 4'h8, rform(5'd8, 2'b11, 4'h2)), 32'h0, 32'h1234_5678, 1, 0);
    // R8: post-indexed with W set is unprivileged
    send("R8", enc(0, 0, 0, 1, 1, 1, 4'h9, 12'h004), 32'h0000_0040, 32'h0, 1, 0);
    send("R8", enc(1, 0, 1, 0, 1, 0, 4'h9, rform(5'd2, 2'b00, 4'h3)), 32'h0000_0040, 32'h3, 1, 0);
    // R9: byte load then word store
    send("R9", enc(0, 1, 1, 1, 0, 1, 4'hA, 12'h001), 32'h10, 32'h0, 1, 0);
    send("R9", enc(0, 1, 1, 0, 0, 0, 4'hA, 12'h001), 32'h10, 32'h0, 1, 0);
    // R2: condition fail, wrong class, bad bit 4
    send("R2", enc(0, 1, 1, 0, 1, 1, 4'hB, 12'h020), 32'h300, 32'h0, 0, 0);
    send("R2", enc(0, 0, 1, 0, 0, 1, 4'hB, 12'h020) ^ 32'h0C00_0000, 32'h300, 32'h0, 1, 0);
    send("R2", enc(1, 1, 1, 0, 1, 1, 4'hB, rform(5'd1, 2'b00, 4'h4) | 12'h010), 32'h300, 32'h5, 1, 0);
    idle();
    repeat (3) @(negedge clk_i);
    check("R1", "scoreboard drained", sb.size(), 32'd0);
    finish_up();
  end
endmodule